// File: doc/BRIEF.md
# Audio Unit Register Front End

This block is the register-side entry point of an audio processing unit. A simple 32-bit register bus (byte address, read strobe, write strobe, write data, registered read data and a stall line) reaches a 512 KiB aperture. The low part of the aperture is a small local register file. Three 64 KiB windows are passed through unchanged to three subunit ports, and every other address reads as zero and drops writes.

Inside the local file sit an interrupt status register with write-one-to-clear semantics, an interrupt enable register, a front-end control register whose method-mode field can force a trap status bit, a free-running 100 ns tick counter, and a memory address and memory data pair. A write to the memory data register stores the value and also launches one 32-bit store request, using valid/ready, to the address held in the memory address register. Bit 0 of both status and enable is the global summary position. The level interrupt line is the registered form of the summary condition.

Top module: `audio_regfront`

## Requirements
- R1: After a synchronous active-low reset every local register reads 0, `irq_o` is low and `mreq_valid` is low.
- R2: Local words at byte offsets 0x08, 0x0C, 0x10, 0x14 and 0x1C to 0x3C are plain read/write storage. `bus_rdata` is valid in the cycle after `bus_rd` is sampled and shows the register as it was before that edge.
- R3: Byte offsets 0x20000-0x2FFFF, 0x30000-0x3FFFF and 0x50000-0x5FFFF select subunit 0, 1 and 2 respectively. The strobe goes out on that subunit's bit of `sub_wr`/`sub_rd` with `sub_addr` = address bits [15:0], and the read returns that subunit's 32-bit lane of `sub_rdata`. At most one subunit strobe is active at a time.
- R4: A write to a local offset beyond the implemented words (below 0x20000) or to the 0x40000, 0x60000 or 0x70000 pages changes nothing. A read there returns 0.
- R5: Status at offset 0x00 is write-one-to-clear: each 1 in the write data clears that status bit, and 0 bits leave their bits unchanged.
- R6: A pulse on `irq_evt` bit n (n >= 2) sets status bit n. A set and a write-one-to-clear of the same bit in the same cycle leaves the bit set. `irq_evt` bits 0 and 1 have no effect.
- R7: When enable (offset 0x04) bit 0 is 1 and some status bit n >= 1 is set with enable bit n also 1, status bit 0 reads 1 and `irq_o` goes high. Both change one clock edge after the status or enable update, not in the same edge.
- R8: When that condition is false, status bit 0 reads 0 and `irq_o` is low one edge later. With enable bit 0 clear, `irq_o` is never high.
- R9: While front-end control (offset 0x08) bits [1:0] equal 2'b10 (trapped), status bit 1 is set on every edge and a write-one-to-clear cannot remove it. After the field changes, the bit stays until it is cleared.
- R10: A write to memory data (offset 0x14) stores the value and raises `mreq_valid` with `mreq_addr` = memory address register (offset 0x10) and `mreq_data` = the written value. Byte 0 is in bits [7:0]. The request holds until `mreq_ready`.
- R11: A write to memory data while a request is pending and `mreq_ready` is low raises `bus_stall` and is not taken. The pending request is held unchanged, and the stalled write completes in the cycle `mreq_ready` is seen. Requests leave in write order.
- R12: Offset 0x18 is a counter that advances by 1 every TICK_DIV clocks (100 ns at the default 250 MHz, TICK_DIV=25) from reset. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 19 | Byte address within the aperture |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| bus_stall | output | 1 | Write not taken this cycle; hold it |
| irq_evt | input | ST_W | Status set pulses |
| irq_o | output | 1 | Level interrupt |
| sub_wr | output | 3 | Per-subunit write strobe |
| sub_rd | output | 3 | Per-subunit read strobe |
| sub_addr | output | 16 | Offset inside the selected window |
| sub_wdata | output | 32 | Write data to subunits |
| sub_rdata | input | 96 | Read data, lane k from subunit k |
| mreq_valid | output | 1 | Store request pending |
| mreq_ready | input | 1 | Store request accepted |
| mreq_addr | output | 32 | Store address |
| mreq_data | output | 32 | Store data |

## Verification
Read data is due in the cycle after the sampled read edge, and the bench captures it 1 ns after that edge. A status or enable write lands on the edge that takes it, while `irq_o` and status bit 0 follow one edge later. The bench therefore checks that the line is unchanged right after the write and has moved after one more edge. A trap-mode write shows in status bit 1 one edge after it lands. A store request appears on the edge that takes the data write. A scoreboard queue holds each expected address/data pair, and a monitor pops one on every valid-and-ready edge, so order and contents are compared when the transfer happens. The stall case counts the stalled cycles before it checks them.

// File: rtl/regfront_pkg.sv
// Shared constants for the audio register front end.
// Assumes a fixed 512 KiB byte aperture and three subunit windows.
package regfront_pkg;
    localparam int AP_W   = 19;           // byte address width of aperture
    localparam int DATA_W = 32;
    localparam int SUB_N  = 3;            // number of subunit windows
    localparam int SUB_AW = 16;           // offset width inside a window

    // 64 KiB page numbers (address bits [18:16]) of each subunit window
    localparam logic [2:0] SUB_PAGE [SUB_N] = '{3'd2, 3'd3, 3'd5};

    // local word indices (byte offset / 4)
    localparam int IDX_STATUS = 0;
    localparam int IDX_ENABLE = 1;
    localparam int IDX_FECTL  = 2;
    localparam int IDX_SECTL  = 3;
    localparam int IDX_MADDR  = 4;
    localparam int IDX_MDATA  = 5;
    localparam int IDX_COUNT  = 6;

    // status/enable bit positions
    localparam int GBIT    = 0;           // global summary
    localparam int TRAPBIT = 1;           // front-end trap

    // front-end method mode encoding
    localparam logic [1:0] FE_TRAPPED = 2'b10;
endpackage

// File: rtl/regfront_decode.sv
// Address decoder: splits a byte address into a local word hit and
// one-hot subunit window hits. Assumes REG_WORDS <= 2^15.
module regfront_decode
    import regfront_pkg::*;
#(
    parameter int REG_WORDS = 16,
    parameter int IDX_W     = $clog2(REG_WORDS)
) (
    input  logic [AP_W-1:0]  addr,
    output logic             loc_hit,
    output logic [IDX_W-1:0] loc_idx,
    output logic [SUB_N-1:0] sub_hit
);
    logic [2:0]  page;
    logic [14:0] word;
    logic [1:0]  unused_byte;

    assign page        = addr[18:16];
    assign word        = addr[16:2];
    assign unused_byte = addr[1:0];

    // local file lives below 0x20000, only implemented words hit
    always_comb begin
        loc_hit = (addr[18:17] == 2'b00) && ({17'd0, word} < REG_WORDS);
        loc_idx = word[IDX_W-1:0];
    end

    // one compare per subunit window
    for (genvar k = 0; k < SUB_N; k++) begin : g_win
        assign sub_hit[k] = (page == SUB_PAGE[k]);
    end
endmodule

// File: rtl/regfront_irq.sv
// Interrupt status/enable pair with write-one-to-clear status,
// event set inputs, trap forcing and a registered summary bit.
// Assumes ST_W >= 2 and ST_W < 32.
module regfront_irq
    import regfront_pkg::*;
#(
    parameter int ST_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_wr,
    input  logic            en_wr,
    input  logic [ST_W-1:0] wdata,
    input  logic [ST_W-1:0] evt,
    input  logic            trap_mode,
    output logic [ST_W-1:0] status,
    output logic [ST_W-1:0] enable,
    output logic            irq
);
    localparam logic [ST_W-1:0] G_MASK   = ST_W'(1) << GBIT;
    localparam logic [ST_W-1:0] EVT_MASK = ~(ST_W'(3));

    logic [ST_W-1:0] st_q, st_d, en_q;
    logic            g_q, g_d;

    // next status: clear, then set (set wins), then trap force
    always_comb begin
        st_d = st_q;
        if (st_wr) st_d = st_d & ~wdata;
        st_d = st_d | (evt & EVT_MASK);
        if (trap_mode) st_d[TRAPBIT] = 1'b1;
        st_d[GBIT] = 1'b0;
    end

    // summary condition on current state
    assign g_d = en_q[GBIT] && (|(st_q & en_q & ~G_MASK));

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            en_q <= '0;
            g_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (en_wr) en_q <= wdata;
            g_q <= g_d;
        end
    end

    assign status = st_q | (g_q ? G_MASK : '0);
    assign enable = en_q;
    assign irq    = g_q;
endmodule

// File: rtl/regfront_memreq.sv
// Single-entry store request holder with valid/ready handshake.
// Assumes the caller only fires when busy is low.
module regfront_memreq #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] req_addr,
    output logic [DW-1:0] req_data,
    output logic          busy
);
    // load on fire, drop on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            req_addr <= '0;
            req_data <= '0;
        end else if (fire) begin
            valid    <= 1'b1;
            req_addr <= addr;
            req_data <= data;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    assign busy = valid && !ready;
endmodule

// File: rtl/regfront_tick.sv
// Free-running counter that advances once every DIV clocks.
module regfront_tick #(
    parameter int DIV = 25,
    parameter int CW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] count
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_q;

    // prescaler and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            count <= '0;
        end else if (pre_q == PW'(DIV - 1)) begin
            pre_q <= '0;
            count <= count + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/audio_regfront.sv
// Register front end of an audio unit: local file, three subunit
// windows, interrupt logic, tick counter and a store side effect.
// Assumes the special word indices of regfront_pkg are < REG_WORDS.
module audio_regfront
    import regfront_pkg::*;
#(
    parameter int REG_WORDS = 16,
    parameter int ST_W      = 8,
    parameter int TICK_DIV  = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AP_W-1:0]         bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_stall,
    input  logic [ST_W-1:0]         irq_evt,
    output logic                    irq_o,
    output logic [SUB_N-1:0]        sub_wr,
    output logic [SUB_N-1:0]        sub_rd,
    output logic [SUB_AW-1:0]       sub_addr,
    output logic [DATA_W-1:0]       sub_wdata,
    input  logic [SUB_N*DATA_W-1:0] sub_rdata,
    output logic                    mreq_valid,
    input  logic                    mreq_ready,
    output logic [DATA_W-1:0]       mreq_addr,
    output logic [DATA_W-1:0]       mreq_data
);
    localparam int IDX_W = $clog2(REG_WORDS);

    logic              loc_hit;
    logic [IDX_W-1:0]  loc_idx;
    logic [SUB_N-1:0]  sub_hit;
    logic              wr_ok, loc_wr, mem_busy, mem_fire;
    logic [ST_W-1:0]   st_view, en_view;
    logic [1:0]        fe_mode;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] view [REG_WORDS];
    logic [DATA_W-1:0] rd_val;

    regfront_decode #(.REG_WORDS(REG_WORDS), .IDX_W(IDX_W)) u_dec (
        .addr    (bus_addr),
        .loc_hit (loc_hit),
        .loc_idx (loc_idx),
        .sub_hit (sub_hit)
    );

    // write acceptance and stall
    assign bus_stall = bus_wr && loc_hit && (loc_idx == IDX_W'(IDX_MDATA)) && mem_busy;
    assign wr_ok     = bus_wr && !bus_stall;
    assign loc_wr    = wr_ok && loc_hit;
    assign mem_fire  = loc_wr && (loc_idx == IDX_W'(IDX_MDATA));

    regfront_irq #(.ST_W(ST_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_wr     (loc_wr && (loc_idx == IDX_W'(IDX_STATUS))),
        .en_wr     (loc_wr && (loc_idx == IDX_W'(IDX_ENABLE))),
        .wdata     (bus_wdata[ST_W-1:0]),
        .evt       (irq_evt),
        .trap_mode (fe_mode == FE_TRAPPED),
        .status    (st_view),
        .enable    (en_view),
        .irq       (irq_o)
    );

    regfront_tick #(.DIV(TICK_DIV), .CW(DATA_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count_q)
    );

    // local word slots: special words come from submodules
    for (genvar i = 0; i < REG_WORDS; i++) begin : g_word
        if (i == IDX_STATUS) begin : g_st
            assign view[i] = DATA_W'(st_view);
        end else if (i == IDX_ENABLE) begin : g_en
            assign view[i] = DATA_W'(en_view);
        end else if (i == IDX_COUNT) begin : g_cnt
            assign view[i] = count_q;
        end else begin : g_plain
            logic [DATA_W-1:0] q;
            // plain storage word
            always_ff @(posedge clk) begin
                if (!rst_n)                                  q <= '0;
                else if (loc_wr && loc_idx == IDX_W'(i))     q <= bus_wdata;
            end
            assign view[i] = q;
        end
    end

    assign fe_mode = view[IDX_FECTL][1:0];

    regfront_memreq #(.DW(DATA_W)) u_mreq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (mem_fire),
        .addr     (view[IDX_MADDR]),
        .data     (bus_wdata),
        .ready    (mreq_ready),
        .valid    (mreq_valid),
        .req_addr (mreq_addr),
        .req_data (mreq_data),
        .busy     (mem_busy)
    );

    // subunit forwarding
    assign sub_wr    = {SUB_N{bus_wr}} & sub_hit;
    assign sub_rd    = {SUB_N{bus_rd}} & sub_hit;
    assign sub_addr  = bus_addr[SUB_AW-1:0];
    assign sub_wdata = bus_wdata;

    // read source select
    always_comb begin
        rd_val = '0;
        if (loc_hit) rd_val = view[loc_idx];
        for (int k = 0; k < SUB_N; k++)
            if (sub_hit[k]) rd_val = sub_rdata[k*DATA_W +: DATA_W];
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end
endmodule

// Assertion checker for audio_regfront.
module regfront_chk #(
    parameter int ST_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_o,
    input logic [ST_W-1:0] en_w,
    input logic [ST_W-1:0] st_w,
    input logic [1:0]      fe_w,
    input logic            mreq_valid,
    input logic            mreq_ready,
    input logic [31:0]     mreq_addr,
    input logic [31:0]     mreq_data,
    input logic [31:0]     cnt_w,
    input logic [2:0]      sub_wr
);
    assert_irq_needs_global_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_w[0]) |-> !irq_o);

    assert_trap_forces_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fe_w) == 2'b10) |-> st_w[1]);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) && $stable(mreq_data)));

    assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_w == $past(cnt_w)) || (cnt_w == $past(cnt_w) + 32'd1));

    assert_sub_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sub_wr));
endmodule

bind audio_regfront regfront_chk #(.ST_W(ST_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_o      (irq_o),
    .en_w       (en_view),
    .st_w       (st_view),
    .fe_w       (fe_mode),
    .mreq_valid (mreq_valid),
    .mreq_ready (mreq_ready),
    .mreq_addr  (mreq_addr),
    .mreq_data  (mreq_data),
    .cnt_w      (count_q),
    .sub_wr     (sub_wr)
);

// File: tb/audio_regfront_tb_top.sv
// Scoreboard bench for audio_regfront.
module audio_regfront_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_stall;
    logic [7:0]  irq_evt = '0;
    logic        irq_o;
    logic [2:0]  sub_wr, sub_rd;
    logic [15:0] sub_addr;
    logic [31:0] sub_wdata;
    logic [95:0] sub_rdata;
    logic        mreq_valid, mreq_ready = 1'b1;
    logic [31:0] mreq_addr, mreq_data;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    audio_regfront #(.TICK_DIV(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_stall(bus_stall), .irq_evt(irq_evt), .irq_o(irq_o),
        .sub_wr(sub_wr), .sub_rd(sub_rd), .sub_addr(sub_addr),
        .sub_wdata(sub_wdata), .sub_rdata(sub_rdata),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
        .mreq_addr(mreq_addr), .mreq_data(mreq_data)
    );

    // subunit model: lane k returns a tagged echo of the offset
    for (genvar k = 0; k < 3; k++) begin : g_sub
        assign sub_rdata[k*32 +: 32] = 32'hA000_0000 | (32'(k) << 16) | 32'(sub_addr);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // store request scoreboard
    logic [63:0] exp_q [$];
    always @(posedge clk) begin
        if (rst_n && mreq_valid && mreq_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10 actual=%h_%h expected=none", mreq_addr, mreq_data);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                if ({mreq_addr, mreq_data} !== e) begin
                    fails++;
                    $display("FAIL R10/R11 actual=%h_%h expected=%h", mreq_addr, mreq_data, e);
                end
            end
        end
    end

    // subunit write monitor
    int          sub_wcnt = 0;
    logic [2:0]  last_sw;
    logic [15:0] last_sa;
    logic [31:0] last_sd;
    always @(posedge clk) begin
        if (rst_n && |sub_wr) begin
            sub_wcnt++;
            last_sw = sub_wr;
            last_sa = sub_addr;
            last_sd = sub_wdata;
        end
    end

    task automatic wr(input logic [18:0] a, input logic [31:0] d, output int stalls);
        bit st;
        stalls = 0;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (a == 19'h14) exp_q.push_back({dut_maddr, d});
        forever begin
            #1 st = bus_stall;
            @(posedge clk);
            if (!st) break;
            stalls++;
            @(negedge clk);
        end
        #1 bus_wr = 1'b0;
    endtask

    logic [31:0] dut_maddr = '0;   // bench copy of memory address register
    task automatic wrs(input logic [18:0] a, input logic [31:0] d);
        int s;
        if (a == 19'h10) dut_maddr = d;
        wr(a, d, s);
    endtask

    task automatic rd(input logic [18:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c1, c2;
        int s;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1 check("R1 irq", 32'(irq_o), 0);
        check("R1 mreq_valid", 32'(mreq_valid), 0);
        rd(19'h00, v); check("R1 status", v, 0);
        rd(19'h1C, v); check("R1 general", v, 0);
        rd(19'h10, v); check("R1 maddr", v, 0);

        // R2 plain storage
        wrs(19'h1C, 32'hDEADBEEF);
        wrs(19'h3C, 32'h12345678);
        wrs(19'h0C, 32'h0000_00F0);
        rd(19'h1C, v); check("R2 0x1C", v, 32'hDEADBEEF);
        rd(19'h3C, v); check("R2 0x3C", v, 32'h12345678);
        rd(19'h0C, v); check("R2 0x0C", v, 32'h0000_00F0);

        // R4 ignored addresses
        s = sub_wcnt;
        wrs(19'h40, 32'h1111_1111);
        wrs(19'h4_0000, 32'h2222_2222);
        wrs(19'h1_FFFC, 32'h3333_3333);
        rd(19'h40, v); check("R4 beyond words", v, 0);
        rd(19'h4_0000, v); check("R4 page4", v, 0);
        rd(19'h1_FFFC, v); check("R4 top of local", v, 0);
        rd(19'h1C, v); check("R4 no alias", v, 32'hDEADBEEF);
        check("R4 no sub write", 32'(sub_wcnt - s), 0);

        // R3 subunit windows
        wrs(19'h2_0010, 32'hABCD_0001);
        check("R3 sub0 strobe", 32'(last_sw), 32'b001);
        check("R3 sub0 addr", 32'(last_sa), 32'h0010);
        check("R3 sub0 data", last_sd, 32'hABCD_0001);
        wrs(19'h5_0200, 32'h5);
        check("R3 sub2 strobe", 32'(last_sw), 32'b100);
        rd(19'h3_0024, v); check("R3 sub1 read", v, 32'hA001_0024);
        rd(19'h5_FFFC, v); check("R3 sub2 read", v, 32'hA002_FFFC);

        // R6 event set, R5 write-one-to-clear
        @(negedge clk) irq_evt = 8'h53;   // bits 0,1 must be ignored
        @(negedge clk) irq_evt = 8'h00;
        rd(19'h00, v); check("R6 event set", v, 32'h50);
        wrs(19'h00, 32'h10);
        rd(19'h00, v); check("R5 w1c", v, 32'h40);
        wrs(19'h00, 32'h00);
        rd(19'h00, v); check("R5 zero write", v, 32'h40);
        fork
            wrs(19'h00, 32'h20);
            begin @(negedge clk) irq_evt = 8'h20; @(negedge clk) irq_evt = 8'h00; end
        join
        rd(19'h00, v); check("R6 set wins", v, 32'h60);

        // R8 no global enable
        wrs(19'h04, 32'h40);
        repeat (3) @(posedge clk);
        #1 check("R8 no global", 32'(irq_o), 0);

        // R7 assert, one edge late
        wrs(19'h04, 32'h41);
        check("R7 not same edge", 32'(irq_o), 0);
        @(posedge clk); #1 check("R7 irq high", 32'(irq_o), 1);
        rd(19'h00, v); check("R7 summary bit", v, 32'h61);

        // R8 deassert after clear of the enabled source
        wrs(19'h00, 32'h40);
        check("R8 not same edge", 32'(irq_o), 1);
        @(posedge clk); #1 check("R8 irq low", 32'(irq_o), 0);
        rd(19'h00, v); check("R8 summary clear", v, 32'h20);

        // R9 trap forcing
        wrs(19'h08, 32'h2);
        @(posedge clk);
        rd(19'h00, v); check("R9 trap set", v, 32'h22);
        wrs(19'h00, 32'h02);
        rd(19'h00, v); check("R9 clear blocked", v, 32'h22);
        wrs(19'h04, 32'h03);
        repeat (2) @(posedge clk);
        #1 check("R9 trap irq", 32'(irq_o), 1);
        wrs(19'h08, 32'h1);
        @(posedge clk);
        rd(19'h00, v); check("R9 sticky after untrap", v, 32'h23);
        wrs(19'h00, 32'h02);
        repeat (2) @(posedge clk);
        rd(19'h00, v); check("R9 cleared", v, 32'h20);
        #1 check("R9 irq low", 32'(irq_o), 0);

        // R10 store side effect
        wrs(19'h10, 32'h1000_0040);
        wrs(19'h14, 32'hCAFE_F00D);
        rd(19'h14, v); check("R10 data stored", v, 32'hCAFE_F00D);

        // R11 stall while pending
        @(negedge clk) mreq_ready = 1'b0;
        wrs(19'h10, 32'h2000_0000);
        wrs(19'h14, 32'h0000_00A1);
        #1 check("R11 pending", 32'(mreq_valid), 1);
        fork
            wr(19'h14, 32'h0000_00B2, s);
            begin repeat (6) @(negedge clk); mreq_ready = 1'b1; end
        join
        check("R11 stalled cycles", 32'(s >= 4), 1);
        repeat (3) @(posedge clk);
        #1 check("R11 drained", 32'(mreq_valid), 0);
        check("R11 queue empty", 32'(exp_q.size()), 0);

        // R12 counter
        rd(19'h18, c1);
        repeat (39) @(posedge clk);
        rd(19'h18, c2);
        check("R12 rate", c2 - c1, 32'd10);
        wrs(19'h18, 32'hFFFF_FFFF);
        rd(19'h18, v); check("R12 write ignored", 32'(v < 32'h1000), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule